// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block sits between instruction decode and a register file that has two read ports and one write port. It turns one block store or block load into a run of single-register memory transfers. It never addresses a register indirectly. In each step it rewrites one register-number field of the accepted instruction and issues that copy again, so every transfer uses only the register ports that an instruction field can select. While the run is in progress, a stall output holds off the fetch of the next instruction.

There are two modes.

- **Range mode:** the register named in the first operand field moves in each step. That field then counts up until it equals the third operand field, and the end register is included in the run.
- **Mask mode:** the third operand field names the first candidate register. The mask's least significant bit belongs to that register. Each step moves the register only if the current mask bit is 1. The mask then shifts right and the field advances, until no set bit remains. With a 16-bit mask and a starting field of 16, the mask covers registers r16 to r31.

Memory addresses start at the supplied base and advance by one register width after each transfer that actually takes place.

Top module: `mrt_seq`

## Requirements
- R1: After reset, `stall`, `done`, `memRd` and `memWr` are all 0.
- R2: When `startValid` is high while `stall` is low, the instruction is accepted at that clock edge. From the following cycle, `stall` is 1 and the first step is presented, one step per cycle.
- R3: In range mode (`maskMode`=0), step k presents register `fieldA`+k on `stepReg` (counted modulo 64, 6-bit field) and makes a transfer.
- R4: In range mode, the step whose register equals `fieldC` is the last one. That register is still transferred, so `fieldA`==`fieldC` gives exactly one transfer.
- R5: In mask mode (`maskMode`=1), step k presents register `fieldC`+k (modulo 64), and makes a transfer only when bit k of `maskIn` is 1.
- R6: In mask mode, the last step is the one for the highest set bit of `maskIn`. A zero mask gives a single step with no transfer.
- R7: The first transfer uses address `baseAddr`, and each later transfer uses an address 8 higher than the previous transfer. Steps without a transfer do not move the address.
- R8: A transfer drives `memRd` when `isLoad`=1 and `memWr` when `isLoad`=0. The two are never high together.
- R9: `stall` stays 1 from the cycle after acceptance through the last step, and it is 0 in the cycle after the last step. No strobe or `done` appears while `stall` is 0.
- R10: `startValid` while `stall` is 1 is ignored, and the running sequence continues unchanged.
- R11: `done` is a single-cycle pulse that coincides with the last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Decoded block-transfer instruction present |
| isLoad | input | 1 | 1 = memory to registers, 0 = registers to memory |
| maskMode | input | 1 | 1 = mask mode, 0 = range mode |
| fieldA | input | 6 | First register operand field |
| fieldC | input | 6 | Third register operand field |
| maskIn | input | 16 | Mask register value |
| baseAddr | input | 32 | Starting memory address |
| stall | output | 1 | Hold off fetch of the next instruction |
| done | output | 1 | Instruction retires this cycle |
| stepReg | output | 6 | Register number of the current step |
| memAddr | output | 32 | Address of the current transfer |
| memRd | output | 1 | Load strobe for this step |
| memWr | output | 1 | Store strobe for this step |

## Verification
The range-mode sweep covers every start/end pair inside r16 to r31. This distinguishes off-by-one termination (exclusive end) from inclusive end, and it checks the single-register case. A separate range run crosses r63 to r0 to show that the field counts modulo 64.

The mask-mode sweep runs all 256 patterns of the low byte, plus each single high bit, an all-ones mask and a zero mask. These show three things:

- only set bits cause a transfer;
- the address skips nothing across holes in the mask;
- the run ends at the highest set bit, not at a fixed length.

Load and store runs alternate across the sweep. One run also raises `startValid` in the middle of a sequence, to show that it is ignored.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_STEP = 1'b1
  } mrtStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture instruction fields
    logic advance;    // step the operand field (and mask)
    logic bumpAddr;   // a transfer happened: move the address
    logic rangeMode;  // latched mode of the running instruction
  } mrtStrobeT;

endpackage

// File: rtl/mrt_dp.sv
module mrt_dp
  import mrt_pkg::*;
#(
  parameter int REG_W      = 6,
  parameter int MASK_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mrtStrobeT         strobe,
  input  logic [REG_W-1:0]  fieldA,
  input  logic [REG_W-1:0]  fieldC,
  input  logic [MASK_W-1:0] maskIn,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [REG_W-1:0]  stepReg,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rangeEnd,
  output logic              maskLast,
  output logic              maskBit0
);

  localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STEP_BYTES);
  localparam logic [REG_W-1:0]  REG_ONE  = REG_W'(1);

  logic [REG_W-1:0]  curA;
  logic [REG_W-1:0]  curC;
  logic [MASK_W-1:0] maskQ;
  logic [ADDR_W-1:0] addrQ;

  // The first operand field counts in range mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curA <= '0;
    end else if (strobe.load) begin
      curA <= fieldA;
    end else if (strobe.advance && strobe.rangeMode) begin
      curA <= curA + REG_ONE;
    end
  end

  // The third operand field counts, and the mask shifts, in mask mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curC  <= '0;
      maskQ <= '0;
    end else if (strobe.load) begin
      curC  <= fieldC;
      maskQ <= maskIn;
    end else if (strobe.advance && !strobe.rangeMode) begin
      curC  <= curC + REG_ONE;
      maskQ <= maskQ >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.load) begin
      addrQ <= baseAddr;
    end else if (strobe.bumpAddr) begin
      addrQ <= addrQ + ADDR_INC;
    end
  end

  always_comb begin
    stepReg  = strobe.rangeMode ? curA : curC;
    memAddr  = addrQ;
    rangeEnd = (curA == curC);
    maskBit0 = maskQ[0];
    maskLast = ((maskQ >> 1) == '0);
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bumpAddr && !strobe.load) |=> (addrQ == $past(addrQ) + ADDR_INC)) else $error("addr step"); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.bumpAddr && !strobe.load) |=> $stable(addrQ)) else $error("addr hold"); // R7
  AST_RANGE_INC: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.rangeMode && !strobe.load) |=> (curA == $past(curA) + REG_ONE)) else $error("range inc"); // R3
  AST_MASK_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.rangeMode && !strobe.load) |=> (maskQ == ($past(maskQ) >> 1))) else $error("mask shift"); // R5

endmodule

// File: rtl/mrt_ctrl.sv
module mrt_ctrl
  import mrt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  logic      isLoad,
  input  logic      maskMode,
  input  logic      rangeEnd,
  input  logic      maskLast,
  input  logic      maskBit0,
  output mrtStrobeT strobe,
  output logic      stall,
  output logic      done,
  output logic      memRd,
  output logic      memWr
);

  mrtStateT state;
  logic     rangeModeQ;
  logic     isLoadQ;
  logic     busy;
  logic     accept;
  logic     lastStep;
  logic     xfer;

  always_comb begin
    busy     = (state == ST_STEP);
    accept   = !busy && startValid;
    lastStep = rangeModeQ ? rangeEnd : maskLast;
    xfer     = busy && (rangeModeQ || maskBit0);

    strobe.load      = accept;
    strobe.advance   = busy;
    strobe.bumpAddr  = xfer;
    strobe.rangeMode = rangeModeQ;

    stall = busy;
    done  = busy && lastStep;
    memRd = xfer && isLoadQ;
    memWr = xfer && !isLoadQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      rangeModeQ <= 1'b1;
      isLoadQ    <= 1'b0;
    end else if (accept) begin
      state      <= ST_STEP;
      rangeModeQ <= !maskMode;
      isLoadQ    <= isLoad;
    end else if (busy && lastStep) begin
      state <= ST_IDLE;
    end
  end

  AST_DONE_IN_STALL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> stall) else $error("done outside stall"); // R11
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(rangeModeQ) && $stable(isLoadQ)) else $error("mode changed mid run"); // R10

endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
  import mrt_pkg::*;
#(
  parameter int REG_W      = 6,
  parameter int MASK_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              isLoad,
  input  logic              maskMode,
  input  logic [REG_W-1:0]  fieldA,
  input  logic [REG_W-1:0]  fieldC,
  input  logic [MASK_W-1:0] maskIn,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              stall,
  output logic              done,
  output logic [REG_W-1:0]  stepReg,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr
);

  mrtStrobeT strobe;
  logic      rangeEnd;
  logic      maskLast;
  logic      maskBit0;

  mrt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .isLoad     (isLoad),
    .maskMode   (maskMode),
    .rangeEnd   (rangeEnd),
    .maskLast   (maskLast),
    .maskBit0   (maskBit0),
    .strobe     (strobe),
    .stall      (stall),
    .done       (done),
    .memRd      (memRd),
    .memWr      (memWr)
  );

  mrt_dp #(
    .REG_W      (REG_W),
    .MASK_W     (MASK_W),
    .ADDR_W     (ADDR_W),
    .STEP_BYTES (STEP_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fieldA   (fieldA),
    .fieldC   (fieldC),
    .maskIn   (maskIn),
    .baseAddr (baseAddr),
    .stepReg  (stepReg),
    .memAddr  (memAddr),
    .rangeEnd (rangeEnd),
    .maskLast (maskLast),
    .maskBit0 (maskBit0)
  );

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)) else $error("rd and wr together"); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !done) |=> stall) else $error("stall dropped early"); // R9
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !stall) else $error("stall held after done"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stall |-> !(memRd || memWr || done)) else $error("activity while idle"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R11

endmodule

// File: tb/tb_mrt_seq.sv
module tb_mrt_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        isLoad = 1'b0;
  logic        maskMode = 1'b0;
  logic [5:0]  fieldA = '0;
  logic [5:0]  fieldC = '0;
  logic [15:0] maskIn = '0;
  logic [31:0] baseAddr = '0;
  logic        stall, done, memRd, memWr;
  logic [5:0]  stepReg;
  logic [31:0] memAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mrt_seq dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .isLoad(isLoad),
    .maskMode(maskMode), .fieldA(fieldA), .fieldC(fieldC), .maskIn(maskIn),
    .baseAddr(baseAddr), .stall(stall), .done(done), .stepReg(stepReg),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Run one instruction and compare every step against an arithmetic model.
  task automatic runInstr(input bit ld, input bit mm, input logic [5:0] a,
                          input logic [5:0] c, input logic [15:0] m,
                          input logic [31:0] base, input bit intrude);
    logic [5:0]  expReg;
    logic [15:0] expMask;
    logic [31:0] expAddr;
    bit          last;
    bit          xfer;
    int          step;
    @(negedge clk);
    chk("R2", "stall before accept", stall, 0);
    startValid = 1; isLoad = ld; maskMode = mm;
    fieldA = a; fieldC = c; maskIn = m; baseAddr = base;
    @(negedge clk);
    startValid = 0;
    expReg  = mm ? c : a;
    expMask = m;
    expAddr = base;
    step = 0;
    forever begin
      if (mm) begin
        last = ((expMask >> 1) == 0);   // R6
        xfer = expMask[0];              // R5
      end else begin
        last = (expReg == c);           // R4
        xfer = 1;                       // R3
      end
      chk("R2", "stall in step", stall, 1);   // R2, R9
      chk(mm ? "R5" : "R3", "stepReg", stepReg, expReg);
      chk("R8", "memRd", memRd, xfer && ld);
      chk("R8", "memWr", memWr, xfer && !ld);
      if (xfer) chk("R7", "memAddr", memAddr, expAddr);
      chk(mm ? "R6" : "R4", "done/last", done, last); // R11
      if (xfer) expAddr = expAddr + 32'd8;
      expReg = expReg + 6'd1;
      expMask = expMask >> 1;
      step++;
      if (intrude && step == 1) begin
        // R10: a new start while busy must not disturb the run
        startValid = 1; isLoad = !ld; maskMode = !mm;
        fieldA = 6'd5; fieldC = 6'd5; maskIn = 16'h0001; baseAddr = 32'hDEAD0000;
      end
      if (last || step > 70) break;
      @(negedge clk);
      startValid = 0;
    end
    if (step > 70) chk("R4", "runaway sequence", step, 0);
    @(negedge clk);
    startValid = 0;
    chk("R9", "stall after last step", stall, 0);
    chk("R11", "done pulse width", done, 0);
    chk("R9", "no strobe when idle", memRd || memWr, 0);
  endtask

  initial begin
    #2_000_000;
    chk("R9", "watchdog expired", 1, 0);
    summary();
  end

  initial begin
    // R1: reset state
    #1;
    chk("R1", "stall in reset", stall, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "memRd in reset", memRd, 0);
    chk("R1", "memWr in reset", memWr, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "stall after reset", stall, 0);
    chk("R1", "done after reset", done, 0);

    // R3, R4: every inclusive range inside r16..r31
    for (int a = 16; a < 32; a++) begin
      for (int c = a; c < 32; c++) begin
        runInstr((a + c) % 2 == 1, 0, 6'(a), 6'(c), 16'h0, 32'h1000 + 32'(a * 256), 0);
      end
    end
    // R4: single register at both ends of the file; R3: wrap past r63
    runInstr(0, 0, 6'd0, 6'd0, 16'h0, 32'h2000, 0);
    runInstr(1, 0, 6'd63, 6'd63, 16'h0, 32'h2100, 0);
    runInstr(0, 0, 6'd60, 6'd2, 16'h0, 32'h2200, 0);

    // R5, R6: all low-byte masks from r16
    for (int m = 0; m < 256; m++) begin
      runInstr(m[0], 1, 6'd0, 6'd16, 16'(m), 32'h8000 + 32'(m * 16), 0);
    end
    // R6: single high bits, full mask, top bit only; R5 wrap past r63
    for (int b = 8; b < 16; b++) begin
      runInstr(b[0], 1, 6'd0, 6'd16, 16'(1 << b), 32'h9000, 0);
    end
    runInstr(0, 1, 6'd0, 6'd16, 16'hFFFF, 32'hA000, 0);
    runInstr(1, 1, 6'd0, 6'd60, 16'h00A5, 32'hA100, 0);
    runInstr(0, 1, 6'd0, 6'd63, 16'h0000, 32'hA200, 0);

    // R10: start raised while busy, in both modes
    runInstr(0, 0, 6'd16, 6'd23, 16'h0, 32'hB000, 1);
    runInstr(1, 1, 6'd0, 6'd16, 16'h00F3, 32'hB100, 1);

    summary();
  end

endmodule